// File: doc/BRIEF.md
# Transmit Empty Interrupt Controller

This block sits beside the transmit FIFO of an asynchronous serial transmitter. It produces the holding-register-empty flag, a fully-idle flag, and the transmit-empty interrupt request with its identification code. It works from the FIFO occupancy, host write and identification-read strobes, the shift-register busy state, the stop-bit setting and the FIFO and interrupt enable bits.

When the FIFO empties, the empty flag normally follows at once. There is one exception. In FIFO mode, if the FIFO has not held two or more bytes together since the flag last set, the flag is held off for one character time minus the last stop bit. A 16x baud tick times this hold-off. With the interrupt enabled, each setting of the flag raises a request. A holding-register write or an identification-register read withdraws it. With the interrupt disabled, the block reports status only.

Top module: `tx_empty_irq_ctrl`

## Requirements
- R1: After reset `thr_empty_o` and `tx_idle_o` are 1 (with `tsr_busy_i` low), `irq_o` is 0 and `irq_id_o` is 1.
- R2: A non-zero `fifo_level_i` sampled at a clock edge makes `thr_empty_o` 0 after that edge.
- R3: With the FIFO disabled, or after the occupancy has reached 2 or more since the flag last set, `thr_empty_o` returns to 1 on the first edge that samples the occupancy at 0.
- R4: Otherwise, in FIFO mode, the flag sets after 16*(CHAR_BITS-1) ticks of `baud_tick_i`, counted from the edge after the occupancy is first sampled at 0. With `two_stop_i`=1 the count is 16 ticks longer. Cycles without a tick do not count.
- R5: A `thr_wr_i` pulse during the hold-off cancels it. A later empty FIFO starts a fresh full hold-off.
- R6: With `tx_irq_en_i`=1, the edge that sets `thr_empty_o` also raises `irq_o`, and `irq_id_o` reads 2 while it is pending.
- R7: A `thr_wr_i` pulse withdraws the pending request. `irq_id_o` then returns to 1.
- R8: An `iir_rd_i` pulse withdraws the pending request.
- R9: A change of `fifo_en_i` while the flag is 1 and the interrupt is enabled raises `irq_o` on the next edge.
- R10: Setting `tx_irq_en_i` while the flag is 1 raises `irq_o` on the next edge.
- R11: With `tx_irq_en_i`=0, `irq_o` stays 0 and the flag still behaves as in R3 and R4.
- R12: `tx_idle_o` is 1 only when `thr_empty_o` is 1 and `tsr_busy_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enable |
| tx_irq_en_i | input | 1 | Transmit-empty interrupt enable |
| fifo_level_i | input | LVL_W | Transmit FIFO occupancy |
| thr_wr_i | input | 1 | Host write to holding register, one-cycle strobe |
| iir_rd_i | input | 1 | Host read of identification register, one-cycle strobe |
| tsr_busy_i | input | 1 | Shift register holds a character |
| two_stop_i | input | 1 | Two stop bits programmed |
| baud_tick_i | input | 1 | 16x baud enable |
| thr_empty_o | output | 1 | Holding register / FIFO empty flag |
| tx_idle_o | output | 1 | FIFO and shift register both empty |
| irq_o | output | 1 | Transmit-empty interrupt request |
| irq_id_o | output | 4 | Identification code: 2 pending, 1 none |

## Verification
A stale two-byte marker changes which kind of flag assertion occurs. The flag then appears at once where 144 ticks were due, or the reverse, at the first light-load drain. A hold-off counter that misses a cancel shows the flag rising at the original expiry edge instead of a full period later. The bench samples at those exact edges. A pending bit that misses a set or clear source shows up on `irq_o` and `irq_id_o` one edge after the strobe or enable change.

// File: rtl/tx_empty_pkg.sv
package tx_empty_pkg;
  localparam int unsigned IRQ_ID_W = 4;
  localparam logic [IRQ_ID_W-1:0] IRQ_ID_NONE  = 4'h1;
  localparam logic [IRQ_ID_W-1:0] IRQ_ID_THR_E = 4'h2;
endpackage

// File: rtl/tx_seen2_track.sv
module tx_seen2_track #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic             empty_set_i,
  output logic             seen2_o
);
  logic seen2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              seen2_q <= 1'b0;
    else if (empty_set_i)                     seen2_q <= 1'b0;
    else if (fifo_level_i >= LVL_W'(2))       seen2_q <= 1'b1;
  end

  assign seen2_o = seen2_q;

  p_seen2_marks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_level_i >= LVL_W'(2)) |=> seen2_q);
endmodule

// File: rtl/tx_empty_delay.sv
module tx_empty_delay #(
  parameter int unsigned OVS       = 16,
  parameter int unsigned CHAR_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fifo_en_i,
  input  logic level_nz_i,
  input  logic seen2_i,
  input  logic thr_wr_i,
  input  logic tick_i,
  input  logic two_stop_i,
  output logic thr_empty_o,
  output logic set_o
);
  localparam int unsigned DLY_MAX = OVS * CHAR_BITS;
  localparam int unsigned CNT_W   = $clog2(DLY_MAX + 1);
  localparam logic [CNT_W-1:0] TGT_ONE = CNT_W'(OVS * (CHAR_BITS - 1));
  localparam logic [CNT_W-1:0] TGT_TWO = CNT_W'(OVS * CHAR_BITS);

  logic             empty_q, act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt;
  logic             imm, expire, set_now;

  assign tgt     = two_stop_i ? TGT_TWO : TGT_ONE;
  assign imm     = !fifo_en_i || seen2_i;
  assign expire  = act_q && tick_i && (cnt_q == tgt - CNT_W'(1));
  assign set_now = !empty_q && !level_nz_i && !thr_wr_i && (imm || expire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         empty_q <= 1'b1;
    else if (level_nz_i) empty_q <= 1'b0;
    else if (set_now)    empty_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (level_nz_i || thr_wr_i || empty_q || set_now) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign thr_empty_o = empty_q;
  assign set_o       = set_now;

  p_busy_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_nz_i |=> !empty_q);
  p_wr_cancels_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_q && thr_wr_i) |=> !empty_q);
endmodule

// File: rtl/tx_irq_gen.sv
module tx_irq_gen
  import tx_empty_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fifo_en_i,
  input  logic                irq_en_i,
  input  logic                thr_empty_i,
  input  logic                empty_set_i,
  input  logic                level_nz_i,
  input  logic                thr_wr_i,
  input  logic                iir_rd_i,
  output logic                irq_o,
  output logic [IRQ_ID_W-1:0] irq_id_o
);
  logic pend_q, en_q, fen_q;
  logic set_ev, clr_ev;

  // enable rising or FIFO mode change re-arms when already empty
  assign set_ev = irq_en_i && (empty_set_i ||
                  (thr_empty_i && (!en_q || (fifo_en_i != fen_q))));
  assign clr_ev = thr_wr_i || iir_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      fen_q  <= 1'b0;
    end else begin
      en_q  <= irq_en_i;
      fen_q <= fifo_en_i;
      if (!irq_en_i || level_nz_i) pend_q <= 1'b0;
      else if (set_ev)             pend_q <= 1'b1;
      else if (clr_ev)             pend_q <= 1'b0;
    end
  end

  assign irq_o    = pend_q && irq_en_i;
  assign irq_id_o = irq_o ? IRQ_ID_THR_E : IRQ_ID_NONE;

  p_irq_needs_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> thr_empty_i);
  p_rd_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && !set_ev) |=> !pend_q);
  p_polled_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !pend_q);
endmodule

// File: rtl/tx_empty_irq_ctrl.sv
module tx_empty_irq_ctrl
  import tx_empty_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned OVS        = 16,
  parameter int unsigned CHAR_BITS  = 10,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fifo_en_i,
  input  logic                tx_irq_en_i,
  input  logic [LVL_W-1:0]    fifo_level_i,
  input  logic                thr_wr_i,
  input  logic                iir_rd_i,
  input  logic                tsr_busy_i,
  input  logic                two_stop_i,
  input  logic                baud_tick_i,
  output logic                thr_empty_o,
  output logic                tx_idle_o,
  output logic                irq_o,
  output logic [IRQ_ID_W-1:0] irq_id_o
);
  logic level_nz, seen2, empty_set, thr_empty;

  assign level_nz = |fifo_level_i;

  tx_seen2_track #(.LVL_W(LVL_W)) u_seen2 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_level_i(fifo_level_i),
    .empty_set_i (empty_set),
    .seen2_o     (seen2)
  );

  tx_empty_delay #(.OVS(OVS), .CHAR_BITS(CHAR_BITS)) u_delay (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_en_i  (fifo_en_i),
    .level_nz_i (level_nz),
    .seen2_i    (seen2),
    .thr_wr_i   (thr_wr_i),
    .tick_i     (baud_tick_i),
    .two_stop_i (two_stop_i),
    .thr_empty_o(thr_empty),
    .set_o      (empty_set)
  );

  tx_irq_gen u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_en_i  (fifo_en_i),
    .irq_en_i   (tx_irq_en_i),
    .thr_empty_i(thr_empty),
    .empty_set_i(empty_set),
    .level_nz_i (level_nz),
    .thr_wr_i   (thr_wr_i),
    .iir_rd_i   (iir_rd_i),
    .irq_o      (irq_o),
    .irq_id_o   (irq_id_o)
  );

  assign thr_empty_o = thr_empty;
  assign tx_idle_o   = thr_empty && !tsr_busy_i;

  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsr_busy_i |-> !tx_idle_o);
endmodule

// File: tb/sim_tx_empty_irq_ctrl.sv
`timescale 1ns/1ps
module sim_tx_empty_irq_ctrl;
  localparam int LVL_W = 5;
  localparam int D1 = 16 * 9;
  localparam int D2 = 16 * 10;

  logic clk = 0, rst_n = 0;
  logic fen = 1, ien = 0, wr = 0, rd = 0, busy = 0, two = 0, tick = 1, slow = 0;
  logic [LVL_W-1:0] lvl = '0;
  logic empty, idle, irq;
  logic [3:0] id;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(negedge clk) tick <= slow ? ~tick : 1'b1;

  tx_empty_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fen), .tx_irq_en_i(ien),
    .fifo_level_i(lvl), .thr_wr_i(wr), .iir_rd_i(rd), .tsr_busy_i(busy),
    .two_stop_i(two), .baud_tick_i(tick), .thr_empty_o(empty),
    .tx_idle_o(idle), .irq_o(irq), .irq_id_o(id));

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 empty", empty, 1); chk("R1 idle", idle, 1);
    chk("R1 irq", irq, 0);     chk("R1 id", id, 1);
  endtask

  task automatic drain_fast(int peak);
    lvl = LVL_W'(peak); step(1);
    chk("R2 busy clears", empty, 0);
    lvl = '0; step(1);
  endtask

  task automatic t_immediate();
    drain_fast(2);
    chk("R3 seen2 immediate", empty, 1);
    fen = 0; step(1);
    lvl = 1; step(1); lvl = 0; step(1);
    chk("R3 fifo off immediate", empty, 1);
    fen = 1; step(1);
  endtask

  task automatic t_delay(bit two_s, int d);
    two = two_s;
    lvl = 1; step(1); lvl = 0;
    step(d);
    chk("R4 before expiry", empty, 0);
    step(1);
    chk("R4 at expiry", empty, 1);
    two = 0;
  endtask

  task automatic t_slow_tick();
    slow = 1;
    lvl = 1; step(1); lvl = 0;
    step(D1 + 40);
    chk("R4 ticks gated", empty, 0);
    step(D1 + 10);
    chk("R4 slow expiry", empty, 1);
    slow = 0; step(2);
  endtask

  task automatic t_cancel();
    lvl = 1; step(1); lvl = 0;
    step(50);
    wr = 1; step(1);
    wr = 0; lvl = 1; step(1);
    lvl = 0; step(100);
    chk("R5 cancelled", empty, 0);
    step(44);
    chk("R5 fresh window", empty, 0);
    step(1);
    chk("R5 fresh expiry", empty, 1);
  endtask

  task automatic t_irq();
    ien = 1; step(1);
    chk("R10 enable raises", irq, 1); chk("R10 id", id, 2);
    rd = 1; step(1); rd = 0;
    chk("R8 read clears", irq, 0); chk("R8 id", id, 1);
    lvl = 2; step(1);
    chk("R6 no irq while busy", irq, 0);
    lvl = 0; step(1);
    chk("R6 irq on empty", irq, 1); chk("R6 id", id, 2);
    wr = 1; step(1); wr = 0;
    chk("R7 write clears", irq, 0); chk("R7 id", id, 1);
    step(2);
    fen = 0; step(1);
    chk("R9 fifo off change", irq, 1);
    rd = 1; step(1); rd = 0;
    fen = 1; step(1);
    chk("R9 fifo on change", irq, 1);
    rd = 1; step(1); rd = 0;
    chk("R8 read clears again", irq, 0);
  endtask

  task automatic t_polled();
    ien = 0; step(1);
    lvl = 2; step(1); lvl = 0; step(1);
    chk("R11 flag sets", empty, 1); chk("R11 no irq", irq, 0);
    fen = 0; step(1); fen = 1; step(1);
    chk("R11 no irq on mode change", irq, 0);
  endtask

  task automatic t_idle();
    busy = 1; step(1);
    chk("R12 shifter busy", idle, 0);
    busy = 0; step(1);
    chk("R12 all idle", idle, 1);
    lvl = 1; step(1);
    chk("R12 fifo busy", idle, 0);
    lvl = 0; step(1);
  endtask

  initial begin
    step(2); rst_n = 1; step(1);
    t_reset();
    t_immediate();
    t_delay(0, D1);
    t_delay(1, D2);
    t_slow_tick();
    t_cancel();
    t_irq();
    t_polled();
    t_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule